// File: doc/BRIEF.md
# LPC Memory Write Target

This block is the target side of a Low Pin Count bus port that accepts host-issued memory writes. It watches the frame strobe and the four-bit multiplexed address/data lines. When it sees a valid start followed by a memory-write cycle type, it shifts in a 32-bit address and one data byte, one nibble per clock. It stays off the lines while the host turns the bus around. It then answers with a single ready sync nibble, drives its own turnaround nibble for one clock and releases the lines.

In the sync clock the block raises a one-clock write strobe, which carries the captured address and data to whatever sits behind it, such as a flash command decoder. The bidirectional lines are modelled as separate input, output and output-enable signals. If the host asserts the frame strobe again partway through a cycle, the target drops the cycle and treats the current nibble as a fresh start candidate. An active-low asynchronous reset returns the block to idle with the lines released.

Top module: `lpc_mem_wr_target`

## Requirements
- R1: While `rst_ni` is low, `lad_oe_o` and `wr_strobe_o` are 0, and `wr_addr_o` and `wr_data_o` read 0.
- R2: A cycle begins only on a clock where `lframe_ni` is 0 and `lad_i` is 4'b0000. Any other nibble with `lframe_ni` low starts nothing, so no sync and no strobe follow.
- R3: The clock after the start must carry a cycle-type nibble whose bits [3:1] are 3'b011, with bit 0 ignored. Any other value abandons the cycle with no drive and no strobe.
- R4: The next 8 clocks carry the address, most significant nibble first, and the full 32 bits appear on `wr_addr_o` during the strobe.
- R5: The next 2 clocks carry the data byte, low nibble first (bits [3:0] and then bits [7:4]), and the byte appears on `wr_data_o` during the strobe.
- R6: `lad_oe_o` stays 0 from the start clock through both host turnaround clocks that follow the data.
- R7: On the clock after the second host turnaround clock, the target drives 4'b0000 (ready) with `lad_oe_o` high, for exactly one clock.
- R8: `wr_strobe_o` is high for exactly one clock, in the sync clock, and for no rejected or aborted cycle.
- R9: On the clock after sync, the target drives 4'b1111 with `lad_oe_o` high for one clock, and `lad_oe_o` is 0 on the clock after that.
- R10: If `lframe_ni` goes low during a cycle, the target is not driving on the next clock and gives no strobe for the dropped cycle. If the nibble at that point is 4'b0000, a new cycle starts from it.
- R11: A new start can be accepted on the clock right after the target's own turnaround, so cycles can run back to back with no idle clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lframe_ni | input | 1 | Frame strobe from the host, active low |
| lad_i | input | 4 | Nibble sampled from the shared lines |
| lad_o | output | 4 | Nibble driven onto the shared lines |
| lad_oe_o | output | 1 | Output enable for `lad_o` |
| wr_strobe_o | output | 1 | One-clock write request |
| wr_addr_o | output | 32 | Captured write address |
| wr_data_o | output | 8 | Captured write byte |

## Verification
The assertions check on every clock the properties that need only local timing. The strobe lasts one clock and always coincides with a driven ready nibble. The turnaround nibble follows sync and is released one clock later. A low frame strobe silences the target on the next clock, and reset keeps the outputs quiet. The bench scenarios cover what depends on a whole cycle's content: the nibble order of the address and data, the rejection of bad start and type nibbles, the exact clock of sync, abort and restart at arbitrary positions, and cycles that run back to back.

// File: rtl/lpc_wr_pkg.sv
package lpc_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_DATA,
    ST_HTAR,
    ST_SYNC,
    ST_PTAR
  } lpc_state_e;

  localparam logic [3:0] START_NIB  = 4'b0000;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] TAR_NIB    = 4'b1111;
  localparam logic [2:0] CT_MEMWR   = 3'b011;
endpackage

// File: rtl/lpc_wr_capture.sv
module lpc_wr_capture #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        lad_i,
  input  logic              addr_shift_i,
  input  logic              data_load_i,
  input  logic [CNT_W-1:0]  data_idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int DATA_NIBS = DATA_W / 4;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // address arrives MSN first: shift left
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           addr_q <= '0;
    else if (addr_shift_i) addr_q <= {addr_q[ADDR_W-5:0], lad_i};
  end

  // data arrives LSN first: each nibble slot has its own enable
  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_dnib
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        data_q[g*4 +: 4] <= '0;
      else if (data_load_i && (data_idx_i == CNT_W'(g)))
        data_q[g*4 +: 4] <= lad_i;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/lpc_wr_ctrl.sv
module lpc_wr_ctrl
  import lpc_wr_pkg::*;
#(
  parameter int ADDR_NIBS = 8,
  parameter int DATA_NIBS = 2,
  parameter int TAR_CLKS  = 2,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lframe_ni,
  input  logic [3:0]       lad_i,
  output lpc_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             addr_shift_o,
  output logic             data_load_o
);
  lpc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!lframe_ni) begin
      // frame strobe overrides everything: restart or drop
      state_d = (lad_i == START_NIB) ? ST_CTYPE : ST_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE:  ;
        ST_CTYPE: begin
          state_d = (lad_i[3:1] == CT_MEMWR) ? ST_ADDR : ST_IDLE;
          cnt_d   = '0;
        end
        ST_ADDR: begin
          if (cnt_q == CNT_W'(ADDR_NIBS - 1)) begin
            state_d = ST_DATA;
            cnt_d   = '0;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        ST_DATA: begin
          if (cnt_q == CNT_W'(DATA_NIBS - 1)) begin
            state_d = ST_HTAR;
            cnt_d   = '0;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        ST_HTAR: begin
          if (cnt_q == CNT_W'(TAR_CLKS - 1)) begin
            state_d = ST_SYNC;
            cnt_d   = '0;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        ST_SYNC:  state_d = ST_PTAR;
        ST_PTAR:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o      = state_q;
  assign cnt_o        = cnt_q;
  assign addr_shift_o = lframe_ni && (state_q == ST_ADDR);
  assign data_load_o  = lframe_ni && (state_q == ST_DATA);
endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
  import lpc_wr_pkg::*;
(
  input  lpc_state_e state_i,
  output logic [3:0] lad_o,
  output logic       lad_oe_o,
  output logic       wr_strobe_o
);
  always_comb begin
    lad_o       = TAR_NIB;
    lad_oe_o    = 1'b0;
    wr_strobe_o = 1'b0;
    case (state_i)
      ST_SYNC: begin
        lad_o       = SYNC_READY;
        lad_oe_o    = 1'b1;
        wr_strobe_o = 1'b1;
      end
      ST_PTAR: begin
        lad_o    = TAR_NIB;
        lad_oe_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpc_mem_wr_target.sv
module lpc_mem_wr_target
  import lpc_wr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 8,
  parameter int TAR_CLKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lframe_ni,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic              wr_strobe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int DATA_NIBS = DATA_W / 4;
  localparam int CNT_W     = $clog2(ADDR_NIBS + 1);

  lpc_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             addr_shift;
  logic             data_load;

  lpc_wr_ctrl #(
    .ADDR_NIBS(ADDR_NIBS),
    .DATA_NIBS(DATA_NIBS),
    .TAR_CLKS (TAR_CLKS),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lframe_ni   (lframe_ni),
    .lad_i       (lad_i),
    .state_o     (state),
    .cnt_o       (cnt),
    .addr_shift_o(addr_shift),
    .data_load_o (data_load)
  );

  lpc_wr_capture #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lad_i       (lad_i),
    .addr_shift_i(addr_shift),
    .data_load_i (data_load),
    .data_idx_i  (cnt),
    .addr_o      (wr_addr_o),
    .data_o      (wr_data_o)
  );

  lpc_lad_drive u_drive (
    .state_i    (state),
    .lad_o      (lad_o),
    .lad_oe_o   (lad_oe_o),
    .wr_strobe_o(wr_strobe_o)
  );
endmodule

// File: rtl/lpc_mem_wr_target_chk.sv
module lpc_mem_wr_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lframe_ni,
  input logic [3:0] lad_o,
  input logic       lad_oe_o,
  input logic       wr_strobe_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!lad_oe_o && !wr_strobe_o)
        else $error("outputs active in reset");
    end
  end

  p_strobe_one_clk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |=> !wr_strobe_o);

  p_strobe_with_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> (lad_oe_o && lad_o == 4'b0000));

  p_tar_after_sync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe_o && lframe_ni) |=> (lad_oe_o && lad_o == 4'b1111 && !wr_strobe_o));

  p_release_after_tar_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lad_oe_o && lad_o == 4'b1111) |=> !lad_oe_o);

  p_abort_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_ni |=> (!lad_oe_o && !wr_strobe_o));
endmodule

bind lpc_mem_wr_target lpc_mem_wr_target_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lframe_ni  (lframe_ni),
  .lad_o      (lad_o),
  .lad_oe_o   (lad_oe_o),
  .wr_strobe_o(wr_strobe_o)
);

// File: tb/lpc_mem_wr_target_tb.sv
`timescale 1ns/100ps
module lpc_mem_wr_target_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        oe;
  logic        strobe;
  logic [31:0] addr;
  logic [7:0]  data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpc_mem_wr_target u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .lframe_ni  (lframe_n),
    .lad_i      (lad_in),
    .lad_o      (lad_out),
    .lad_oe_o   (oe),
    .wr_strobe_o(strobe),
    .wr_addr_o  (addr),
    .wr_data_o  (data)
  );

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // host nibble for clock k of a write cycle
  function automatic logic [3:0] host_nib(input logic [31:0] a, input logic [7:0] d,
                                          input logic [3:0] ct, input logic [3:0] st, input int k);
    if (k == 0) return st;
    if (k == 1) return ct;
    if (k >= 2 && k <= 9) return a[4*(9-k) +: 4];
    if (k == 10) return d[3:0];
    if (k == 11) return d[7:4];
    if (k == 12) return 4'hF;
    return 4'($urandom);
  endfunction

  function automatic bit accepted(input logic [3:0] st, input logic [3:0] ct);
    return (st == 4'h0) && (ct[3:1] == 3'b011);
  endfunction

  task automatic do_write(input logic [31:0] a, input logic [7:0] d, input logic [3:0] ct,
                          input logic [3:0] st, input int abort_at, input bit restart);
    bit acc;
    int ab;
    int k;
    acc = accepted(st, ct);
    ab = abort_at;
    k = 0;
    while (k < 14) begin
      @(negedge clk);
      if (k == 0) chk(!oe && !strobe, "R11", {38'd0, oe, strobe}, 40'd0);
      else        chk(!oe && !strobe, "R6", {38'd0, oe, strobe}, 40'd0);
      if (k == ab && k >= 1) begin
        lframe_n = 1'b0;
        if (restart) begin
          lad_in = 4'h0;
          ab = -1;
          k = 1;
          continue;
        end
        lad_in = 4'h5;
        @(negedge clk);
        chk(!oe && !strobe, "R10", {38'd0, oe, strobe}, 40'd0);
        lframe_n = 1'b1;
        lad_in = 4'hF;
        return;
      end
      lframe_n = (k == 0) ? 1'b0 : 1'b1;
      lad_in = host_nib(a, d, ct, st, k);
      k++;
    end
    @(negedge clk);
    lframe_n = 1'b1;
    lad_in = 4'($urandom);
    if (acc) begin
      chk(oe && lad_out == 4'h0, "R7", {35'd0, oe, lad_out}, {35'd0, 1'b1, 4'h0});
      chk(strobe == 1'b1, "R8", {39'd0, strobe}, 40'd1);
      chk(addr == a, "R4", {8'd0, addr}, {8'd0, a});
      chk(data == d, "R5", {32'd0, data}, {32'd0, d});
    end else if (st != 4'h0) begin
      chk(!oe && !strobe, "R2", {38'd0, oe, strobe}, 40'd0);
    end else begin
      chk(!oe && !strobe, "R3", {38'd0, oe, strobe}, 40'd0);
    end
    @(negedge clk);
    lad_in = 4'($urandom);
    if (acc)
      chk(oe && lad_out == 4'hF && !strobe, "R9", {34'd0, oe, strobe, lad_out}, {34'd0, 1'b1, 1'b0, 4'hF});
    else
      chk(!oe && !strobe, "R8", {38'd0, oe, strobe}, 40'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!oe && !strobe && addr == 0 && data == 0, "R1", {oe, strobe, addr[29:0], data}, 40'd0);
    rst_n = 1'b1;

    // unlock-style command writes, both type bit-0 values
    do_write(32'h0000_5555, 8'hAA, 4'h6, 4'h0, -1, 1'b0);
    do_write(32'hFFFF_2AAA, 8'h55, 4'h7, 4'h0, -1, 1'b0);
    do_write(32'h1234_5555, 8'h80, 4'h6, 4'h0, -1, 1'b0);
    // R3: wrong cycle types
    do_write(32'hDEAD_BEEF, 8'h11, 4'h4, 4'h0, -1, 1'b0);
    do_write(32'hDEAD_BEEF, 8'h11, 4'h2, 4'h0, -1, 1'b0);
    // R2: wrong start nibble
    do_write(32'hCAFE_0001, 8'h22, 4'h6, 4'h2, -1, 1'b0);
    // R10: abort mid-address, then abort-with-restart mid-data
    do_write(32'h0BAD_0BAD, 8'h33, 4'h6, 4'h0, 5, 1'b0);
    do_write(32'h8765_4321, 8'hC3, 4'h6, 4'h0, 10, 1'b1);
    do_write(32'hA5A5_5A5A, 8'h0F, 4'h6, 4'h0, 13, 1'b0);

    // R1: reset in the middle of a cycle
    @(negedge clk); lframe_n = 1'b0; lad_in = 4'h0;
    @(negedge clk); lframe_n = 1'b1; lad_in = 4'h6;
    @(negedge clk); lad_in = 4'h9;
    @(negedge clk); lad_in = 4'h8;
    rst_n = 1'b0;
    #0.5;
    chk(!oe && !strobe && addr == 0, "R1", {oe, strobe, 6'd0, addr}, 40'd0);
    @(negedge clk); rst_n = 1'b1;

    repeat (80) begin
      logic [31:0] ra;
      logic [7:0]  rd;
      logic [3:0]  rct;
      logic [3:0]  rst_nib;
      int          rab;
      ra  = $urandom;
      rd  = 8'($urandom);
      rct = ($urandom % 10 < 8) ? {3'b011, 1'($urandom)} : 4'($urandom);
      rst_nib = ($urandom % 20 == 0) ? 4'(1 + $urandom % 15) : 4'h0;
      rab = ($urandom % 6 == 0) ? int'(1 + $urandom % 13) : -1;
      do_write(ra, rd, rct, rst_nib, rab, (rst_nib == 4'h0) ? 1'($urandom) : 1'b0);
    end

    @(negedge clk);
    chk(!oe && !strobe, "R9", {38'd0, oe, strobe}, 40'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule